// File: doc/BRIEF.md
# Top-down cascaded magnitude comparator

This block compares two unsigned words by chaining 4-bit comparator slices from the most-significant end toward the least-significant end. Each slice receives a one-hot verdict (greater, less or equal) computed over all the bits above it. It hands a refined one-hot verdict to the slice below. A verdict that is already decided on entry leaves the slice unchanged. Only an "equal so far" verdict lets the slice look at its own bit pairs. There, the highest pair that differs settles the outcome.

The top module chains two slices to order two 8-bit words. The slice for bits 7..4 has its cascade inputs tied to "equal". Its outputs drive the cascade inputs of the slice for bits 3..0, and the overall result is read from that lowest slice. The whole path is combinational.

Top module: `cmp_chain8`

## Requirements
- R1: The three outputs of every slice, and of the chain, always have exactly one bit set.
- R2: In a slice, an active cascade-greater input gives outputs greater=1, less=0, equal=0, whatever the local operand bits are.
- R3: In a slice, an active cascade-less input with cascade-greater inactive gives outputs greater=0, less=1, equal=0, whatever the local operand bits are.
- R4: In a slice whose only active cascade input is equal, the highest bit index (3 down to 0) where the operands differ decides: operand A holding 1 there gives greater, operand A holding 0 gives less.
- R5: In a slice whose only active cascade input is equal, identical local operands give outputs greater=0, less=0, equal=1.
- R6: Cascade inputs that are not one-hot resolve by fixed priority: greater over less over equal. When all three are inactive, they count as equal.
- R7: The chain sets greater_o, less_o and equal_o exactly when X>Y, X<Y and X=Y respectively, with X and Y read as unsigned 8-bit numbers.
- R8: When X[7:4] and Y[7:4] differ, the high nibbles alone decide the chain result. When they match, the low nibbles decide it, because the top slice starts from "equal".

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | 8 | First unsigned operand |
| y_i | input | 8 | Second unsigned operand |
| greater_o | output | 1 | X is greater than Y |
| less_o | output | 1 | X is less than Y |
| equal_o | output | 1 | X equals Y |

## Verification
The chain is driven with every one of the 65,536 operand pairs. This separates high-nibble decisions from low-nibble decisions and catches any bit-order mistake in the scan. Directed pairs with the high nibbles opposite to the low nibbles show that a decision made above cannot be overturned below. A standalone slice is driven with all 256 local operand pairs under each of the eight cascade input patterns. The one-hot patterns separate pass-through from local scanning, and the non-one-hot patterns expose the priority order.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    typedef struct packed {
        logic gt;
        logic lt;
        logic eq;
    } rel_t;

    localparam rel_t REL_GT = '{gt: 1'b1, lt: 1'b0, eq: 1'b0};
    localparam rel_t REL_LT = '{gt: 1'b0, lt: 1'b1, eq: 1'b0};
    localparam rel_t REL_EQ = '{gt: 1'b0, lt: 1'b0, eq: 1'b1};

endpackage

// File: rtl/cmp_casc_resolve.sv
module cmp_casc_resolve
    import cmp_pkg::*;
(
    input  logic casc_gt_i,
    input  logic casc_lt_i,
    input  logic casc_eq_i,
    output rel_t casc_o
);

    rel_t casc_d;
    logic none_active;

    always_comb begin
        none_active = !(casc_gt_i || casc_lt_i || casc_eq_i);
        casc_d.gt   = casc_gt_i;
        casc_d.lt   = !casc_gt_i && casc_lt_i;
        casc_d.eq   = !casc_gt_i && !casc_lt_i && (casc_eq_i || none_active);
    end

    assign casc_o = casc_d;

    always_comb begin
        assert ($onehot({casc_o.gt, casc_o.lt, casc_o.eq}))
            else $error("AST_CASC_ONEHOT"); // R6
        if (casc_gt_i)
            assert (casc_o.gt) else $error("AST_CASC_GT_FIRST"); // R6
    end

endmodule

// File: rtl/cmp_bit_scan.sv
module cmp_bit_scan
    import cmp_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output rel_t         loc_o
);

    rel_t loc_d;

    // Walk upward so that the highest differing pair overwrites the lower ones.
    always_comb begin
        loc_d = REL_EQ;
        for (int k = 0; k < W; k++) begin
            if (a_i[k] != b_i[k]) begin
                loc_d = a_i[k] ? REL_GT : REL_LT;
            end
        end
    end

    assign loc_o = loc_d;

    always_comb begin
        assert (loc_o.eq == (a_i == b_i)) else $error("AST_SCAN_EQ"); // R5
        assert (loc_o.gt == (a_i > b_i))  else $error("AST_SCAN_ORDER"); // R4
    end

endmodule

// File: rtl/cmp_slice.sv
module cmp_slice
    import cmp_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         casc_gt_i,
    input  logic         casc_lt_i,
    input  logic         casc_eq_i,
    output logic         gt_o,
    output logic         lt_o,
    output logic         eq_o
);

    rel_t casc_s;
    rel_t loc_s;
    rel_t res_d;

    cmp_casc_resolve i_resolve (
        .casc_gt_i (casc_gt_i),
        .casc_lt_i (casc_lt_i),
        .casc_eq_i (casc_eq_i),
        .casc_o    (casc_s)
    );

    cmp_bit_scan #(.W(W)) i_scan (
        .a_i   (a_i),
        .b_i   (b_i),
        .loc_o (loc_s)
    );

    always_comb begin
        if (casc_s.gt) begin
            res_d = REL_GT;
        end else if (casc_s.lt) begin
            res_d = REL_LT;
        end else begin
            res_d = loc_s;
        end
    end

    assign gt_o = res_d.gt;
    assign lt_o = res_d.lt;
    assign eq_o = res_d.eq;

    always_comb begin
        assert ($onehot({gt_o, lt_o, eq_o})) else $error("AST_SLICE_ONEHOT"); // R1
        if (casc_gt_i)
            assert (gt_o && !lt_o && !eq_o) else $error("AST_GT_PASS"); // R2
        if (!casc_gt_i && casc_lt_i)
            assert (lt_o && !gt_o && !eq_o) else $error("AST_LT_PASS"); // R3
        if (!casc_gt_i && !casc_lt_i)
            assert (eq_o == (a_i == b_i)) else $error("AST_LOCAL_EQ"); // R5
    end

endmodule

// File: rtl/cmp_chain8.sv
module cmp_chain8 #(
    parameter int SLICE_W    = 4,
    parameter int NUM_SLICES = 2,
    localparam int DATA_W    = SLICE_W * NUM_SLICES
) (
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    output logic              greater_o,
    output logic              less_o,
    output logic              equal_o
);

    // link[s+1] enters slice s; link[NUM_SLICES] is the tie-off, link[0] the result.
    logic [NUM_SLICES:0] gt_l;
    logic [NUM_SLICES:0] lt_l;
    logic [NUM_SLICES:0] eq_l;

    assign gt_l[NUM_SLICES] = 1'b0;
    assign lt_l[NUM_SLICES] = 1'b0;
    assign eq_l[NUM_SLICES] = 1'b1;

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        cmp_slice #(.W(SLICE_W)) i_slice (
            .a_i       (x_i[s*SLICE_W +: SLICE_W]),
            .b_i       (y_i[s*SLICE_W +: SLICE_W]),
            .casc_gt_i (gt_l[s+1]),
            .casc_lt_i (lt_l[s+1]),
            .casc_eq_i (eq_l[s+1]),
            .gt_o      (gt_l[s]),
            .lt_o      (lt_l[s]),
            .eq_o      (eq_l[s])
        );
    end

    assign greater_o = gt_l[0];
    assign less_o    = lt_l[0];
    assign equal_o   = eq_l[0];

    always_comb begin
        assert ($onehot({greater_o, less_o, equal_o})) else $error("AST_CHAIN_ONEHOT"); // R1
        assert (greater_o == (x_i > y_i)) else $error("AST_CHAIN_GT"); // R7
        assert (less_o == (x_i < y_i))    else $error("AST_CHAIN_LT"); // R7
        if (x_i[DATA_W-1 -: SLICE_W] != y_i[DATA_W-1 -: SLICE_W])
            assert (greater_o == (x_i[DATA_W-1 -: SLICE_W] > y_i[DATA_W-1 -: SLICE_W]))
                else $error("AST_TOP_DECIDES"); // R8
    end

endmodule

// File: tb/test_cmp_chain8.sv
module test_cmp_chain8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] x, y;
    logic       gt, lt, eq;
    logic [3:0] sa, sb;
    logic       cg, cl, ce;
    logic       sgt, slt, seq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    cmp_chain8 i_cmp_chain8 (
        .x_i(x), .y_i(y), .greater_o(gt), .less_o(lt), .equal_o(eq)
    );

    cmp_slice #(.W(4)) i_slice (
        .a_i(sa), .b_i(sb), .casc_gt_i(cg), .casc_lt_i(cl), .casc_eq_i(ce),
        .gt_o(sgt), .lt_o(slt), .eq_o(seq)
    );

    task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got gt/lt/eq=%b expected=%b (x=%h y=%h a=%h b=%h casc=%b%b%b)",
                     tag, got, exp, x, y, sa, sb, cg, cl, ce);
        end
    endtask

    function automatic logic [2:0] order3(input int a, input int b);
        if (a > b) return 3'b100;
        if (a < b) return 3'b010;
        return 3'b001;
    endfunction

    task automatic t_reset();
        x = 8'h00; y = 8'h00; sa = 4'h0; sb = 4'h0; cg = 0; cl = 0; ce = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R5 idle chain equal", {gt, lt, eq}, 3'b001);
        check("R5 idle slice equal", {sgt, slt, seq}, 3'b001);
    endtask

    task automatic t_slice_patterns();
        for (int p = 0; p < 8; p++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    logic [2:0] exp;
                    @(negedge clk);
                    {cg, cl, ce} = p[2:0];
                    sa = a[3:0]; sb = b[3:0];
                    #1;
                    if (p[2])      exp = 3'b100;
                    else if (p[1]) exp = 3'b010;
                    else           exp = order3(a, b);
                    if (p == 4)      check("R2 casc greater pass", {sgt, slt, seq}, exp);
                    else if (p == 2) check("R3 casc less pass", {sgt, slt, seq}, exp);
                    else if (p == 1) check("R4 local scan", {sgt, slt, seq}, exp);
                    else             check("R6 casc priority", {sgt, slt, seq}, exp);
                    if ($countones({sgt, slt, seq}) != 1)
                        check("R1 slice one-hot", {sgt, slt, seq}, exp);
                end
            end
        end
    endtask

    task automatic t_directed();
        @(negedge clk); x = 8'hA3; y = 8'h5F; #1;
        check("R8 high nibble wins over low", {gt, lt, eq}, 3'b100);
        @(negedge clk); x = 8'h30; y = 8'h4F; #1;
        check("R8 high nibble less", {gt, lt, eq}, 3'b010);
        @(negedge clk); x = 8'h47; y = 8'h46; #1;
        check("R8 low nibble decides", {gt, lt, eq}, 3'b100);
        @(negedge clk); x = 8'hFF; y = 8'hFF; #1;
        check("R5 all ones equal", {gt, lt, eq}, 3'b001);
        @(negedge clk); sa = 4'b1000; sb = 4'b0111; {cg, cl, ce} = 3'b001; #1;
        check("R4 top bit decides", {sgt, slt, seq}, 3'b100);
        @(negedge clk); sa = 4'b0100; sb = 4'b0101; #1;
        check("R4 bit 0 decides", {sgt, slt, seq}, 3'b010);
    endtask

    task automatic t_exhaustive();
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                @(negedge clk);
                x = a[7:0]; y = b[7:0];
                #1;
                check("R7 chain order", {gt, lt, eq}, order3(a, b));
            end
        end
    endtask

    initial begin
        t_reset();
        t_directed();
        t_slice_patterns();
        t_exhaustive();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #900000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired: got running expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule